// File: doc/BRIEF.md
# Single-Channel Request-Driven DMA Engine

This block is one DMA channel that copies data items between a peripheral address and a memory address. Software programs a source and a destination address, an item count and a control word through a small word-indexed register port. Then it sets the enable bit. Each rising edge on the chosen peripheral request line makes the channel move one item. The move is a read followed by a write over a single-beat bus with a valid/ready handshake. After each item the channel steps the addresses and decrements the remaining count.

The channel raises half-way, done and bus-error flags, each gated onto a shared interrupt line by its own enable. A circular setting reloads the block for continuous streaming. A memory-to-memory setting runs items back to back without waiting for requests. A 4-bit selector field picks one of up to sixteen request lines. That field lives in a register shared with neighbouring channels, at bit position 4 × `CH_IDX`.

Register word indices on `reg_addr`: 0 control, 1 count, 2 peripheral address, 3 memory address, 4 status (read only), 5 flag clear (write only, reads zero), 6 request select.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every readable register reads zero, `bus_valid` and `irq` are low, and no transfer starts.
- R2: The count register (index 1) takes a write only while control bit 0 (enable) is 0. A write made while enable is 1 leaves the count unchanged.
- R3: Each serviced item makes one read access followed by one write access. Each access holds `bus_valid`, `bus_addr` and `bus_write` stable until `bus_ready`. After the item the count, readable at any time, is one lower.
- R4: Control bit 4 selects the direction. With 0 the channel reads at the peripheral address and writes at the memory address; with 1 it does the reverse. Read data is masked to the source item size before it is written.
- R5: Bits 9:8 give the peripheral item size and bits 11:10 the memory item size (0 = 8, 1 = 16, 2 or 3 = 32 bits). When bit 6 (peripheral) or bit 7 (memory) is set, that address steps by the item size in bytes after each item. When the bit is clear, the address stays fixed.
- R6: Status bit 1 (half) is set when the count left after an item equals the programmed count shifted right by one. Status bit 0 (done) is set when the count reaches zero.
- R7: `irq` is high exactly when a status flag is set and its enable is set. The enables are control bit 1 for done, bit 2 for half and bit 3 for error.
- R8: With control bit 5 (circular) set, the item that brings the count to zero reloads the programmed count and both programmed start addresses, and requests keep being served.
- R9: With circular clear, the channel serves no request while the count is zero.
- R10: Writing ones to register 5 clears the matching status bits. Writes to the status register (index 4) have no effect.
- R11: Register 6 holds a 4-bit selector at bits 4×CH_IDX+3:4×CH_IDX, and all its other bits read zero. Only rising edges on `periph_req[selector]` trigger items.
- R12: With enable clear no new item starts, and the count and addresses keep their values.
- R13: An error response on either access sets status bit 2 and clears enable. The count and addresses are not updated for that item.
- R14: With control bit 12 (memory-to-memory) set, items run back to back without requests until the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| periph_req | input | NUM_REQ | Peripheral request lines |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_size | output | 2 | Access size, same encoding as item size |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access completes |
| bus_err | input | 1 | Error response, valid with `bus_ready` |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the engine with `CH_IDX` = 2 and `NUM_REQ` = 16. The selector field then sits in bits 11:8 of the shared register, away from bit 0, so a wrong field offset or a read-back that leaks other bits shows up. It also means all sixteen lines can be addressed, so a request on an unselected line can be shown to do nothing. Its bus model answers with an error above a fixed address, which exercises the error path and the enable clear that follows it. Mixed item sizes (8-bit memory reads written as 16-bit peripheral stores) exercise the masking and the per-side address steps.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int unsigned AW = 32;

  // control word, bit 0 first: en, tc_ie, ht_ie, te_ie, dir, circ,
  // pinc, minc, psize[9:8], msize[11:10], m2m[12], prio[14:13]
  typedef struct packed {
    logic [1:0] prio;
    logic       m2m;
    logic [1:0] msize;
    logic [1:0] psize;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
    logic       te_ie;
    logic       ht_ie;
    logic       tc_ie;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  localparam logic [2:0] RI_CTRL  = 3'd0;
  localparam logic [2:0] RI_COUNT = 3'd1;
  localparam logic [2:0] RI_PADDR = 3'd2;
  localparam logic [2:0] RI_MADDR = 3'd3;
  localparam logic [2:0] RI_STAT  = 3'd4;
  localparam logic [2:0] RI_FCLR  = 3'd5;
  localparam logic [2:0] RI_RSEL  = 3'd6;

  localparam int unsigned FL_TC = 0;
  localparam int unsigned FL_HT = 1;
  localparam int unsigned FL_TE = 2;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'd0:    size_step = 3'd1;
      2'd1:    size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

  function automatic logic [AW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CH_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             item_done,
  input  logic             bus_fault,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] cnt,
  output logic [AW-1:0]    paddr,
  output logic [AW-1:0]    maddr,
  output logic [3:0]       rsel,
  output logic             irq
);

  localparam int unsigned SEL_LSB = 4 * CH_IDX;

  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d, cnt_dec;
  logic [AW-1:0]    paddr_q, paddr_d, pstart_q, pstart_d;
  logic [AW-1:0]    maddr_q, maddr_d, mstart_q, mstart_d;
  logic [2:0]       flags_q, flags_d, flags_set, flags_clr;
  logic [3:0]       rsel_q, rsel_d;
  logic             cnt_last;
  logic [AW-1:0]    pstep, mstep;

  assign cnt_dec  = cnt_q - 1'b1;
  assign cnt_last = (cnt_dec == '0);
  assign pstep    = ctrl_q.pinc ? {29'd0, size_step(ctrl_q.psize)} : '0;
  assign mstep    = ctrl_q.minc ? {29'd0, size_step(ctrl_q.msize)} : '0;

  always_comb begin
    ctrl_d    = ctrl_q;
    cnt_d     = cnt_q;
    rld_d     = rld_q;
    paddr_d   = paddr_q;
    pstart_d  = pstart_q;
    maddr_d   = maddr_q;
    mstart_d  = mstart_q;
    rsel_d    = rsel_q;
    flags_set = '0;
    flags_clr = '0;

    if (item_done) begin
      if (cnt_last && ctrl_q.circ) begin
        cnt_d   = rld_q;
        paddr_d = pstart_q;
        maddr_d = mstart_q;
      end else begin
        cnt_d   = cnt_dec;
        paddr_d = paddr_q + pstep;
        maddr_d = maddr_q + mstep;
      end
      flags_set[FL_TC] = cnt_last;
      flags_set[FL_HT] = (cnt_dec == (rld_q >> 1));
    end

    if (reg_we) begin
      case (reg_addr)
        RI_CTRL:  ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RI_COUNT: if (!ctrl_q.en) begin
                    cnt_d = reg_wdata[CNT_W-1:0];
                    rld_d = reg_wdata[CNT_W-1:0];
                  end
        RI_PADDR: begin
                    paddr_d  = reg_wdata;
                    pstart_d = reg_wdata;
                  end
        RI_MADDR: begin
                    maddr_d  = reg_wdata;
                    mstart_d = reg_wdata;
                  end
        RI_FCLR:  flags_clr = reg_wdata[2:0];
        RI_RSEL:  rsel_d = reg_wdata[SEL_LSB +: 4];
        default:  ;
      endcase
    end

    if (bus_fault) begin
      ctrl_d.en        = 1'b0;
      flags_set[FL_TE] = 1'b1;
    end

    flags_d = (flags_q & ~flags_clr) | flags_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cnt_q    <= '0;
      rld_q    <= '0;
      paddr_q  <= '0;
      pstart_q <= '0;
      maddr_q  <= '0;
      mstart_q <= '0;
      flags_q  <= '0;
      rsel_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      cnt_q    <= cnt_d;
      rld_q    <= rld_d;
      paddr_q  <= paddr_d;
      pstart_q <= pstart_d;
      maddr_q  <= maddr_d;
      mstart_q <= mstart_d;
      flags_q  <= flags_d;
      rsel_q   <= rsel_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_CTRL:  reg_rdata[CTRL_W-1:0] = ctrl_q;
      RI_COUNT: reg_rdata[CNT_W-1:0]  = cnt_q;
      RI_PADDR: reg_rdata = paddr_q;
      RI_MADDR: reg_rdata = maddr_q;
      RI_STAT:  reg_rdata[2:0] = flags_q;
      RI_RSEL:  reg_rdata[SEL_LSB +: 4] = rsel_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign ctrl  = ctrl_q;
  assign cnt   = cnt_q;
  assign paddr = paddr_q;
  assign maddr = maddr_q;
  assign rsel  = rsel_q;
  assign irq   = (flags_q[FL_TC] & ctrl_q.tc_ie) |
                 (flags_q[FL_HT] & ctrl_q.ht_ie) |
                 (flags_q[FL_TE] & ctrl_q.te_ie);

  // R2
  cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q.en) && !$past(item_done)) |-> $stable(cnt_q));

  // R6
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FL_TC]) |-> $past(item_done));

  // R13
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> (!ctrl_q.en && flags_q[FL_TE]));

  // R9
  block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && ctrl_q.en && cnt_q == 1 && !ctrl_q.circ) |=> (cnt_q == '0));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && ctrl_q.en && cnt_q == 1 && ctrl_q.circ) |=> (cnt_q == $past(rld_q)));

endmodule

// File: rtl/dmach_reqsel.sv
module dmach_reqsel #(
  parameter int unsigned NUM_REQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic [3:0]         sel,
  input  logic               arm,
  input  logic               take,
  output logic               pending
);

  logic [15:0] req_pad;
  logic        line, line_q, pend_q, pend_d, rise;

  for (genvar i = 0; i < 16; i++) begin : g_pad
    if (i < NUM_REQ) begin : g_live
      assign req_pad[i] = periph_req[i];
    end else begin : g_tie
      assign req_pad[i] = 1'b0;
    end
  end

  assign line = req_pad[sel];
  assign rise = line & ~line_q;

  always_comb begin
    pend_d = arm & ((pend_q & ~take) | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      line_q <= line;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
  import dmach_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          m2m,
  input  logic          dir,
  input  logic [1:0]    psize,
  input  logic [1:0]    msize,
  input  logic          cnt_nz,
  input  logic          pending,
  input  logic [AW-1:0] paddr,
  input  logic [AW-1:0] maddr,
  output logic          take,
  output logic          item_done,
  output logic          bus_fault,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [31:0]   bus_rdata
);

  xfer_state_e state_q, state_d;
  logic [31:0] data_q;
  logic        data_en;
  logic [1:0]  src_size, dst_size;
  logic [AW-1:0] src_addr, dst_addr;

  assign src_size = dir ? msize : psize;
  assign dst_size = dir ? psize : msize;
  assign src_addr = dir ? maddr : paddr;
  assign dst_addr = dir ? paddr : maddr;

  always_comb begin
    state_d   = state_q;
    take      = 1'b0;
    item_done = 1'b0;
    bus_fault = 1'b0;
    data_en   = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_size  = src_size;
    bus_addr  = src_addr;
    bus_wdata = '0;
    case (state_q)
      XS_IDLE: begin
        if (en && cnt_nz && (pending || m2m)) begin
          take    = 1'b1;
          state_d = XS_READ;
        end
      end
      XS_READ: begin
        bus_valid = 1'b1;
        if (bus_ready) begin
          if (bus_err) begin
            bus_fault = 1'b1;
            state_d   = XS_IDLE;
          end else begin
            data_en = 1'b1;
            state_d = XS_WRITE;
          end
        end
      end
      XS_WRITE: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_size  = dst_size;
        bus_addr  = dst_addr;
        bus_wdata = data_q & size_mask(dst_size);
        if (bus_ready) begin
          state_d = XS_IDLE;
          if (bus_err) bus_fault = 1'b1;
          else         item_done = 1'b1;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= bus_rdata & size_mask(src_size);
    end
  end

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

  // R12
  start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(en));

  // R9
  start_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(cnt_nz));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dmach_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REQ = 16,
  parameter int unsigned CH_IDX  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] periph_req,
  output logic               bus_valid,
  output logic               bus_write,
  output logic [1:0]         bus_size,
  output logic [31:0]        bus_addr,
  output logic [31:0]        bus_wdata,
  input  logic               bus_ready,
  input  logic               bus_err,
  input  logic [31:0]        bus_rdata,
  output logic               irq
);

  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    paddr, maddr;
  logic [3:0]       rsel;
  logic             pending, take, item_done, bus_fault;

  dmach_regs #(
    .CNT_W  (CNT_W),
    .CH_IDX (CH_IDX)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_s2),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .item_done (item_done),
    .bus_fault (bus_fault),
    .ctrl      (ctrl),
    .cnt       (cnt),
    .paddr     (paddr),
    .maddr     (maddr),
    .rsel      (rsel),
    .irq       (irq)
  );

  dmach_reqsel #(
    .NUM_REQ (NUM_REQ)
  ) u_reqsel (
    .clk        (clk),
    .rst_n      (rst_s2),
    .periph_req (periph_req),
    .sel        (rsel),
    .arm        (ctrl.en),
    .take       (take),
    .pending    (pending)
  );

  dmach_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_s2),
    .en        (ctrl.en),
    .m2m       (ctrl.m2m),
    .dir       (ctrl.dir),
    .psize     (ctrl.psize),
    .msize     (ctrl.msize),
    .cnt_nz    (cnt != '0),
    .pending   (pending),
    .paddr     (paddr),
    .maddr     (maddr),
    .take      (take),
    .item_done (item_done),
    .bus_fault (bus_fault),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

  localparam int NREQ = 16;

  localparam logic [31:0] C_EN   = 32'h1;
  localparam logic [31:0] C_TCIE = 32'h2;
  localparam logic [31:0] C_TEIE = 32'h8;
  localparam logic [31:0] C_DIR  = 32'h10;
  localparam logic [31:0] C_CIRC = 32'h20;
  localparam logic [31:0] C_PINC = 32'h40;
  localparam logic [31:0] C_MINC = 32'h80;
  localparam logic [31:0] C_P32  = 32'h200;
  localparam logic [31:0] C_P16  = 32'h100;
  localparam logic [31:0] C_M32  = 32'h800;
  localparam logic [31:0] C_M2M  = 32'h1000;

  logic            clk, rst_n;
  logic            reg_we;
  logic [2:0]      reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic [NREQ-1:0] periph_req;
  logic            bus_valid, bus_write;
  logic [1:0]      bus_size;
  logic [31:0]     bus_addr, bus_wdata, bus_rdata;
  logic            bus_ready, bus_err;
  logic            irq;

  int total = 0;
  int bad   = 0;
  logic [7:0] mem [0:4095];

  dma_chan_engine #(.CNT_W(16), .NUM_REQ(NREQ), .CH_IDX(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] rd32(input logic [11:0] a);
    return {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else if (bus_valid && !bus_ready) begin
      bus_ready <= 1'b1;
      bus_err   <= (bus_addr[31:28] == 4'hF);
      bus_rdata <= rd32(bus_addr[11:0]);
      if (bus_write && bus_addr[31:28] != 4'hF) begin
        mem[bus_addr[11:0]] <= bus_wdata[7:0];
        if (bus_size != 2'd0) mem[bus_addr[11:0] + 12'd1] <= bus_wdata[15:8];
        if (bus_size[1]) begin
          mem[bus_addr[11:0] + 12'd2] <= bus_wdata[23:16];
          mem[bus_addr[11:0] + 12'd3] <= bus_wdata[31:24];
        end
      end
    end else begin
      bus_ready <= 1'b0;
      bus_err   <= 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + 12'(i)] = v[8*i +: 8];
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    periph_req[line] = 1'b1;
    @(negedge clk);
    periph_req[line] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      reg_read(3'(i), v);
      check($sformatf("R1 reg %0d after reset", i), v, 32'h0);
    end
    check("R1 bus_valid idle", {31'd0, bus_valid}, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    reg_write(3'd6, 32'hFFFF_FFFF);
    reg_read(3'd6, v);
    check("R11 selector field only", v, 32'h0000_0F00);
    reg_write(3'd6, 32'h0000_0500);
    reg_write(3'd2, 32'h100);
    reg_write(3'd3, 32'h200);
    reg_write(3'd1, 32'd4);
    reg_write(3'd0, C_EN | C_TCIE | C_MINC | C_P32 | C_M32);
    wr32(12'h100, 32'hA1A2A3A4);
    pulse(5);
    wr32(12'h100, 32'hB1B2B3B4);
    pulse(5);
    reg_read(3'd1, v);
    check("R3 count after two items", v, 32'd2);
    check("R3 first item stored", rd32(12'h200), 32'hA1A2A3A4);
    check("R3 second item stored", rd32(12'h204), 32'hB1B2B3B4);
    reg_read(3'd3, v);
    check("R5 memory address stepped", v, 32'h208);
    reg_read(3'd2, v);
    check("R5 fixed peripheral address", v, 32'h100);
    reg_read(3'd4, v);
    check("R6 half flag at midpoint", v, 32'h2);
    check("R7 half flag masked", {31'd0, irq}, 32'd0);
    pulse(3);
    reg_read(3'd1, v);
    check("R11 unselected line ignored", v, 32'd2);
    reg_write(3'd1, 32'd9);
    reg_read(3'd1, v);
    check("R2 count write while enabled", v, 32'd2);
    pulse(5);
    pulse(5);
    reg_read(3'd1, v);
    check("R3 count reaches zero", v, 32'd0);
    reg_read(3'd4, v);
    check("R6 done flag", v, 32'h3);
    check("R7 done irq", {31'd0, irq}, 32'd1);
    wr32(12'h210, 32'h5555_5555);
    pulse(5);
    check("R9 no item past end", rd32(12'h210), 32'h5555_5555);
    reg_read(3'd3, v);
    check("R9 address held past end", v, 32'h210);
    reg_write(3'd4, 32'h0);
    reg_read(3'd4, v);
    check("R10 status write ignored", v, 32'h3);
    reg_write(3'd5, 32'h2);
    reg_read(3'd4, v);
    check("R10 clear half only", v, 32'h1);
    check("R7 irq held by done", {31'd0, irq}, 32'd1);
    reg_write(3'd5, 32'h1);
    check("R7 irq after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_dir_sizes;
    logic [31:0] v;
    reg_write(3'd0, 32'h0);
    mem[12'h300] = 8'h11; mem[12'h301] = 8'h22; mem[12'h302] = 8'h33;
    mem[12'h401] = 8'hEE;
    reg_write(3'd3, 32'h300);
    reg_write(3'd2, 32'h400);
    reg_write(3'd1, 32'd3);
    reg_write(3'd0, C_EN | C_DIR | C_PINC | C_MINC | C_P16);
    pulse(5); pulse(5); pulse(5);
    check("R4 first halfword", {16'd0, mem[12'h401], mem[12'h400]}, 32'h0011);
    check("R4 third halfword", {16'd0, mem[12'h405], mem[12'h404]}, 32'h0033);
    reg_read(3'd2, v);
    check("R5 peripheral step by two", v, 32'h406);
    reg_read(3'd3, v);
    check("R5 memory step by one", v, 32'h303);
  endtask

  task automatic t_circ;
    logic [31:0] v;
    reg_write(3'd0, 32'h0);
    reg_write(3'd5, 32'h7);
    reg_write(3'd2, 32'h100);
    reg_write(3'd3, 32'h500);
    reg_write(3'd1, 32'd2);
    reg_write(3'd0, C_EN | C_CIRC | C_MINC | C_P32 | C_M32);
    pulse(5); pulse(5);
    reg_read(3'd1, v);
    check("R8 count reloaded", v, 32'd2);
    reg_read(3'd3, v);
    check("R8 address reloaded", v, 32'h500);
    reg_read(3'd4, v);
    check("R8 done flag on wrap", v & 32'h1, 32'h1);
    pulse(5);
    reg_read(3'd1, v);
    check("R8 keeps serving", v, 32'd1);
    reg_write(3'd0, C_CIRC | C_MINC | C_P32 | C_M32);
    pulse(5);
    reg_read(3'd1, v);
    check("R12 disabled count held", v, 32'd1);
    reg_read(3'd3, v);
    check("R12 disabled address held", v, 32'h504);
    reg_write(3'd1, 32'd7);
    reg_read(3'd1, v);
    check("R2 count write while disabled", v, 32'd7);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    reg_write(3'd5, 32'h7);
    reg_write(3'd2, 32'hF000_0000);
    reg_write(3'd3, 32'h800);
    reg_write(3'd1, 32'd3);
    reg_write(3'd0, C_EN | C_TEIE | C_MINC | C_P32 | C_M32);
    pulse(5);
    reg_read(3'd4, v);
    check("R13 error flag", v, 32'h4);
    reg_read(3'd0, v);
    check("R13 enable cleared", v & 32'h1, 32'h0);
    reg_read(3'd1, v);
    check("R13 count kept", v, 32'd3);
    reg_read(3'd3, v);
    check("R13 address kept", v, 32'h800);
    check("R7 error irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_m2m;
    logic [31:0] v;
    reg_write(3'd5, 32'h7);
    reg_write(3'd0, 32'h0);
    for (int i = 0; i < 4; i++) wr32(12'h600 + 12'(4*i), 32'hC0DE_0000 + 32'(i));
    reg_write(3'd2, 32'h600);
    reg_write(3'd3, 32'h700);
    reg_write(3'd1, 32'd4);
    reg_write(3'd0, C_EN | C_M2M | C_PINC | C_MINC | C_P32 | C_M32);
    repeat (60) @(negedge clk);
    reg_read(3'd1, v);
    check("R14 block drained", v, 32'd0);
    for (int i = 0; i < 4; i++)
      check($sformatf("R14 word %0d copied", i), rd32(12'h700 + 12'(4*i)), 32'hC0DE_0000 + 32'(i));
    reg_read(3'd4, v);
    check("R14 flags at end", v, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; periph_req = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_dir_sizes();
    t_circ();
    t_fault();
    t_m2m();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule